// File: doc/BRIEF.md
# Card Access Timing Calculator

This block turns a requested card access time, given in nanoseconds, into the three bus-clock cycle counts that a card strobe controller needs: a setup count, a strobe-length count and a hold count. The caller pulses a start input together with the access time, a flag that marks an I/O window as opposed to a memory window, the bus clock frequency in MHz, and the bus-monitor timeout limit in cycles. Some dozens of cycles later the block pulses done and presents the three counts together with a flag that reports whether the request had to be clamped.

The access time is first replaced by a default when it is zero. It is then converted to cycles with an 80% safety stretch. The total is clamped to one cycle below the bus-monitor limit, so that a slow card can never trip the bus timeout. Finally the total is split roughly one seventh, five sevenths and one seventh. The truncation loss of that split goes to setup, so the three counts always add up to the total. The conversion uses a multi-cycle restoring divider. This keeps the long constant division off the critical path.

Top module: `acc_timing_calc`

## Requirements
- R1: While reset is asserted and after it is released, before the first result, setup_o, strobe_o and hold_o are 0, clamped_o is 0 and done_o is 0.
- R2: An access time of 0 is treated as 255 ns when is_io_i is 1 and as 100 ns when is_io_i is 0.
- R3: The total cycle count is floor(ns × MHz × 180 / 100000), computed without overflow for every input value.
- R4: If the total is greater than or equal to limit_i, the total becomes limit_i − 1 and clamped_o is 1; otherwise clamped_o is 0 and the total is kept.
- R5: hold_o equals floor(total / 7) and strobe_o equals floor(5 × total / 7).
- R6: setup_o equals floor(total / 7) plus whatever the split left over, so that setup_o + strobe_o + hold_o equals the total.
- R7: Each accepted start produces exactly one done_o pulse, one cycle wide, no more than 40 clock cycles after the start.
- R8: A start_i pulse that arrives while a calculation is running is ignored: it neither changes the running result nor produces an extra done_o.
- R9: setup_o, strobe_o, hold_o and clamped_o hold their values from the done_o pulse until the next accepted start completes, whatever the data inputs do in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request pulse; inputs are sampled with it |
| access_ns_i | input | NS_W (16) | Requested access time in ns, 0 selects the default |
| is_io_i | input | 1 | 1 for an I/O window, 0 for a memory window |
| bus_mhz_i | input | MHZ_W (10) | Bus clock frequency in MHz |
| limit_i | input | FLD_W (6) | Bus-monitor timeout in cycles |
| setup_o | output | FLD_W (6) | Setup cycles |
| strobe_o | output | FLD_W (6) | Strobe-length cycles |
| hold_o | output | FLD_W (6) | Hold cycles |
| clamped_o | output | 1 | Total was clamped below the limit |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The hardest case to reach is a total that sits exactly on the clamp boundary, because the stretch and the truncating division hide the total behind the product of two inputs. The stimulus table picks access-time and frequency pairs whose stretched products fall just below and just at the limit: 333 ns and 334 ns at 100 MHz give 59 and 60 cycles against a limit of 60. A second hard case is a start that lands in the middle of a running division. The bench issues it a few cycles after an accepted start and with different operands. It then checks that the original result arrives alone.

// File: rtl/acc_timing_pkg.sv
package acc_timing_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } calc_state_e;

endpackage

// File: rtl/acc_seq_divider.sv
// Restoring divider by a constant, one quotient bit per clock.
module acc_seq_divider #(
    parameter int W       = 34,
    parameter int DIVISOR = 100000
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    output logic [W-1:0] quotient_o,
    output logic         done_o
);
    localparam int DV_W  = $clog2(DIVISOR + 1);
    localparam int CNT_W = $clog2(W);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [DV_W-1:0]  rem;
        logic [W-1:0]     quo;
        logic             done;
    } div_s;

    div_s r_q, r_d;
    logic [DV_W:0] trial;
    logic          fits;

    always_comb begin
        r_d   = r_q;
        r_d.done = 1'b0;
        trial = {r_q.rem, r_q.quo[W-1]};
        fits  = trial >= (DV_W + 1)'(DIVISOR);
        if (!r_q.busy) begin
            if (start_i) begin
                r_d.busy = 1'b1;
                r_d.cnt  = '0;
                r_d.rem  = '0;
                r_d.quo  = dividend_i;
            end
        end else begin
            if (fits) begin
                r_d.rem = DV_W'(trial - (DV_W + 1)'(DIVISOR));
            end else begin
                r_d.rem = trial[DV_W-1:0];
            end
            r_d.quo = {r_q.quo[W-2:0], fits};
            if (r_q.cnt == CNT_W'(W - 1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign quotient_o = r_q.quo;
    assign done_o     = r_q.done;

endmodule

// File: rtl/acc_cycle_split.sv
// Splits a cycle total 1/7 : 5/7 : 1/7, remainder into setup.
module acc_cycle_split #(
    parameter int FLD_W = 6
) (
    input  logic [FLD_W-1:0] total_i,
    output logic [FLD_W-1:0] setup_o,
    output logic [FLD_W-1:0] strobe_o,
    output logic [FLD_W-1:0] hold_o
);
    localparam int WIDE_W = FLD_W + 3;

    logic [WIDE_W-1:0] five_x;
    logic [WIDE_W-1:0] strobe_w;
    logic [FLD_W-1:0]  seventh;

    always_comb begin
        five_x   = WIDE_W'(total_i) * WIDE_W'(5);
        strobe_w = five_x / WIDE_W'(7);
        seventh  = total_i / FLD_W'(7);
        hold_o   = seventh;
        strobe_o = strobe_w[FLD_W-1:0];
        setup_o  = total_i - seventh - strobe_w[FLD_W-1:0];
    end

endmodule

// File: rtl/acc_timing_calc.sv
module acc_timing_calc
    import acc_timing_pkg::*;
#(
    parameter int NS_W           = 16,
    parameter int MHZ_W          = 10,
    parameter int FLD_W          = 6,
    parameter int IO_DEFAULT_NS  = 255,
    parameter int MEM_DEFAULT_NS = 100,
    parameter int STRETCH_PCT    = 180,
    parameter int SCALE_DIV      = 100000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [NS_W-1:0]  access_ns_i,
    input  logic             is_io_i,
    input  logic [MHZ_W-1:0] bus_mhz_i,
    input  logic [FLD_W-1:0] limit_i,
    output logic [FLD_W-1:0] setup_o,
    output logic [FLD_W-1:0] strobe_o,
    output logic [FLD_W-1:0] hold_o,
    output logic             clamped_o,
    output logic             done_o
);
    localparam int STR_W  = $clog2(STRETCH_PCT + 1);
    localparam int PROD_W = NS_W + MHZ_W + STR_W;

    typedef struct packed {
        calc_state_e      st;
        logic [FLD_W-1:0] lim;
        logic [FLD_W-1:0] setup;
        logic [FLD_W-1:0] strobe;
        logic [FLD_W-1:0] hold;
        logic             clamped;
        logic             done;
    } calc_s;

    calc_s r_q, r_d;

    logic [NS_W-1:0]   eff_ns;
    logic [PROD_W-1:0] product;
    logic              div_start;
    logic [PROD_W-1:0] quotient;
    logic              div_done;
    logic              over;
    logic [FLD_W-1:0]  lim_m1;
    logic [FLD_W-1:0]  total;
    logic [FLD_W-1:0]  sp_setup, sp_strobe, sp_hold;

    // Signals observed by the bound checker.
    logic              calc_busy;
    logic [FLD_W-1:0]  lim_q;

    always_comb begin
        if (access_ns_i == '0) begin
            eff_ns = is_io_i ? NS_W'(IO_DEFAULT_NS) : NS_W'(MEM_DEFAULT_NS);
        end else begin
            eff_ns = access_ns_i;
        end
        product   = PROD_W'(eff_ns) * PROD_W'(bus_mhz_i) * PROD_W'(STRETCH_PCT);
        div_start = (r_q.st == ST_IDLE) && start_i;
    end

    acc_seq_divider #(
        .W       (PROD_W),
        .DIVISOR (SCALE_DIV)
    ) i_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (div_start),
        .dividend_i (product),
        .quotient_o (quotient),
        .done_o     (div_done)
    );

    always_comb begin
        over   = quotient >= PROD_W'(r_q.lim);
        lim_m1 = (r_q.lim == '0) ? '0 : r_q.lim - 1'b1;
        total  = over ? lim_m1 : quotient[FLD_W-1:0];
    end

    acc_cycle_split #(
        .FLD_W (FLD_W)
    ) i_split (
        .total_i  (total),
        .setup_o  (sp_setup),
        .strobe_o (sp_strobe),
        .hold_o   (sp_hold)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_RUN;
                    r_d.lim = limit_i;
                end
            end
            ST_RUN: begin
                if (div_done) begin
                    r_d.st      = ST_IDLE;
                    r_d.setup   = sp_setup;
                    r_d.strobe  = sp_strobe;
                    r_d.hold    = sp_hold;
                    r_d.clamped = over;
                    r_d.done    = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign setup_o   = r_q.setup;
    assign strobe_o  = r_q.strobe;
    assign hold_o    = r_q.hold;
    assign clamped_o = r_q.clamped;
    assign done_o    = r_q.done;
    assign calc_busy = (r_q.st == ST_RUN);
    assign lim_q     = r_q.lim;

endmodule

// File: rtl/acc_timing_calc_chk.sv
module acc_timing_calc_chk #(
    parameter int FLD_W = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy_i,
    input logic [FLD_W-1:0] lim_i,
    input logic [FLD_W-1:0] setup_i,
    input logic [FLD_W-1:0] strobe_i,
    input logic [FLD_W-1:0] hold_i,
    input logic             clamped_i,
    input logic             done_i
);
    logic [FLD_W+1:0] sum;
    assign sum = (FLD_W + 2)'(setup_i) + (FLD_W + 2)'(strobe_i) + (FLD_W + 2)'(hold_i);

    p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    p_done_from_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> $past(busy_i));

    p_clamp_total_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && clamped_i && lim_i != '0) |-> sum == (FLD_W + 2)'(lim_i) - 1'b1);

    p_below_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !clamped_i) |-> sum < (FLD_W + 2)'(lim_i));

    p_setup_ge_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> setup_i >= hold_i);

    p_ratio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> (FLD_W + 3)'(strobe_i) >= (FLD_W + 3)'(hold_i) * 5);

    p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && start_i) |=> $stable(lim_i));

    p_hold_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && !start_i) |=> ($stable(setup_i) && $stable(strobe_i)
                                   && $stable(hold_i) && $stable(clamped_i)));

endmodule

bind acc_timing_calc acc_timing_calc_chk #(
    .FLD_W (FLD_W)
) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_i    (calc_busy),
    .lim_i     (lim_q),
    .setup_i   (setup_o),
    .strobe_i  (strobe_o),
    .hold_i    (hold_o),
    .clamped_i (clamped_o),
    .done_i    (done_o)
);

// File: tb/test_acc_timing_calc.sv
module test_acc_timing_calc;
    localparam int CLK_PERIOD = 10;
    localparam int NS_W  = 16;
    localparam int MHZ_W = 10;
    localparam int FLD_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [NS_W-1:0]  ns = '0;
    logic             io = 1'b0;
    logic [MHZ_W-1:0] mhz = '0;
    logic [FLD_W-1:0] lim = '0;
    logic [FLD_W-1:0] setup, strobe, hold;
    logic             clamped, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_timing_calc i_acc_timing_calc (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .access_ns_i (ns),
        .is_io_i     (io),
        .bus_mhz_i   (mhz),
        .limit_i     (lim),
        .setup_o     (setup),
        .strobe_o    (strobe),
        .hold_o      (hold),
        .clamped_o   (clamped),
        .done_o      (done)
    );

    typedef struct packed {
        logic [15:0] ns;
        logic [9:0]  mhz;
        logic        io;
        logic [5:0]  lim;
        logic        clamp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{16'd100,   10'd50,   1'b0, 6'd60, 1'b0},
        '{16'd0,     10'd66,   1'b1, 6'd60, 1'b0},
        '{16'd0,     10'd80,   1'b0, 6'd60, 1'b0},
        '{16'd600,   10'd50,   1'b0, 6'd60, 1'b0},
        '{16'd700,   10'd50,   1'b1, 6'd60, 1'b1},
        '{16'd1000,  10'd80,   1'b0, 6'd48, 1'b1},
        '{16'd333,   10'd100,  1'b0, 6'd60, 1'b0},
        '{16'd334,   10'd100,  1'b0, 6'd60, 1'b1},
        '{16'd1,     10'd1,    1'b1, 6'd60, 1'b0},
        '{16'd65535, 10'd1023, 1'b1, 6'd60, 1'b1},
        '{16'd300,   10'd33,   1'b0, 6'd48, 1'b0}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input longint n_in, input longint f, input bit is_io, input longint l,
                         output longint tot, output longint s, output longint st,
                         output longint h, output bit c);
        longint n;
        n   = (n_in == 0) ? (is_io ? 255 : 100) : n_in;
        tot = (n * f * 180) / 100000;
        c   = 1'b0;
        if (tot >= l) begin
            tot = (l > 0) ? l - 1 : 0;
            c   = 1'b1;
        end
        h  = tot / 7;
        st = (tot * 5) / 7;
        s  = tot - h - st;
    endtask

    task automatic pulse_start(input logic [NS_W-1:0] a, input logic [MHZ_W-1:0] f,
                               input logic is_io, input logic [FLD_W-1:0] l);
        @(negedge clk);
        ns = a; mhz = f; io = is_io; lim = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Returns number of cycles waited; 0 if no done within the window.
    task automatic wait_done(output int waited);
        waited = 0;
        for (int k = 1; k <= 200; k++) begin
            if (done) begin
                waited = k;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_result(input vec_t v, input bit exp_clamp_known);
        longint t, s, st, h;
        bit c;
        model(v.ns, v.mhz, v.io, v.lim, t, s, st, h, c);
        if (v.ns == 0)
            check(setup + strobe + hold == t, "R2 defaulted total", setup + strobe + hold, t);
        else
            check(setup + strobe + hold == t, "R3 total cycles", setup + strobe + hold, t);
        check(clamped == c, "R4 clamp flag", clamped, c);
        if (exp_clamp_known)
            check(clamped == v.clamp, "R4 table clamp", clamped, v.clamp);
        check(hold == h, "R5 hold", hold, h);
        check(strobe == st, "R5 strobe", strobe, st);
        check(setup == s, "R6 setup", setup, s);
    endtask

    initial begin : watchdog
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog R7 actual=%0d expected=%0d", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        int w;
        logic [FLD_W-1:0] s0, st0, h0;
        logic c0;
        int extra;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(setup == 0 && strobe == 0 && hold == 0, "R1 fields in reset", setup + strobe + hold, 0);
        check(done == 0 && clamped == 0, "R1 flags in reset", {done, clamped}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(setup == 0 && strobe == 0 && hold == 0 && done == 0, "R1 after release",
              setup + strobe + hold + done, 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            pulse_start(VECS[i].ns, VECS[i].mhz, VECS[i].io, VECS[i].lim);
            wait_done(w);
            check(w != 0 && w <= 39, "R7 done latency", w, 39);
            if (w != 0) check_result(VECS[i], 1'b1);
            @(negedge clk);
            check(done == 0, "R7 done one cycle", done, 0);
        end

        // R8: start while busy is ignored
        pulse_start(16'd600, 10'd50, 1'b0, 6'd60);
        repeat (4) @(negedge clk);
        ns = 16'd1000; mhz = 10'd80; io = 1'b1; lim = 6'd48; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(w);
        check(w != 0, "R8 first done present", w, 1);
        if (w != 0) begin
            check(setup + strobe + hold == 54, "R8 running result kept", setup + strobe + hold, 54);
            check(clamped == 0, "R8 clamp from first request", clamped, 0);
        end
        s0 = setup; st0 = strobe; h0 = hold; c0 = clamped;
        extra = 0;
        // R9: outputs held while data inputs move without start
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (done) extra++;
            ns = NS_W'(k * 37); mhz = MHZ_W'(k * 11); io = k[0]; lim = FLD_W'(k);
        end
        check(extra == 0, "R8 no extra done", extra, 0);
        check(setup == s0 && strobe == st0 && hold == h0, "R9 fields held",
              setup + strobe + hold, s0 + st0 + h0);
        check(clamped == c0, "R9 clamp held", clamped, c0);

        // R4 boundary at a 48-cycle limit: 320 ns at 83 MHz gives 47, 321 ns gives 47 too
        pulse_start(16'd320, 10'd83, 1'b0, 6'd48);
        wait_done(w);
        check(w != 0, "R4 boundary done", w, 1);
        check(setup + strobe + hold == 47 && clamped == 0, "R4 just below limit",
              setup + strobe + hold, 47);
        pulse_start(16'd322, 10'd83, 1'b0, 6'd48);
        wait_done(w);
        check(setup + strobe + hold == 47 && clamped == 1, "R4 at limit clamps",
              clamped, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule